// File: doc/BRIEF.md
# Averaging Serial Audio DAC Driver

This block turns a low-rate unsigned mono sample stream into the three-wire serial format that a 16-bit stereo audio converter expects. The system clock is divided by four to make the converter's bit clock, keeping it well below the converter's 10 MHz limit. Each output frame lasts 21 bit-clock periods: 16 periods that shift one data word out, most significant bit first, followed by 5 idle periods during which the converter moves the received word to its analog output.

The input is not decimated by picking one sample per frame. It is box-filtered instead: the driver adds the current input value into an accumulator once per bit-clock period, so each frame collects 21 samples. The raw sum, with no division, becomes the next output word. With a 10-bit input, the largest sum is 1023 × 21 = 21483, which fits in 16 bits. The sum is unsigned, so it is turned into the converter's two's-complement format by inverting its top bit. A word-select line changes level once per frame to commit the word. As a result, consecutive frames land in alternate channels and both channels carry the same stream.

Top module: `dacavg_drv`

## Requirements
- R1: The bit clock `bck_o` has a period of exactly 4 system clock cycles: 2 cycles low followed by 2 cycles high.
- R2: One frame is 21 bit-clock periods. The first 16 periods carry data bits, and during the 5 idle periods that follow, `sdata_o` is 0.
- R3: `sdata_o` changes only together with a falling edge of `bck_o` and is stable while `bck_o` is high. Each word is sent with its most significant bit (bit 15) in the first period of the frame and bit 0 in the sixteenth.
- R4: Over each frame, the driver sums the value of `sample_i` once in every one of the 21 bit-clock periods, with no division or scaling.
- R5: The transmitted word is the 16-bit unsigned sum with bit 15 inverted. For example, a sum of 0 is sent as 16'h8000.
- R6: The word built from frame N is sent in frame N+1. The accumulator starts each frame empty, so no sample counts toward two words.
- R7: `ws_o` changes level exactly once per frame. The change falls on the bit-clock falling edge that ends the sixteenth data bit.
- R8: While `rst` is high, `bck_o`, `sdata_o` and `ws_o` are all 0. The first frame after reset transmits the word 16'h0000 (signed zero).
- R9: A full-scale input of 1023 in every period gives the sum 21483 without overflow, sent as 16'hD3EB.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System master clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_i | input | IN_W (10) | Unsigned audio sample |
| bck_o | output | 1 | Converter bit clock (clk / 4) |
| sdata_o | output | 1 | Serial data, MSB first, updated on the falling bit-clock edge |
| ws_o | output | 1 | Word-select / latch, toggles once per frame |

## Verification
The bench acts as the converter. It captures `sdata_o` on every rising `bck_o` and, in parallel, builds the expected word from the samples it applied. It applies silence, full scale, a ramp, an alternating 0/1023 pattern and a scrambled sequence, so the offset by one frame, the top-bit inversion and the no-overflow limit are each exposed. A design that drops or doubles the frame's boundary sample produces sums that are off by one sample. A design that sign-extends instead of inverting, or reuses the word from the current frame, fails on the all-zero and ramp frames. A word-select change placed one period early or late, and data that moves while the bit clock is high, are both caught on every frame.

// File: rtl/dacavg_pkg.sv
package dacavg_pkg;

    // Width needed to hold a sum of `states` unsigned samples of `in_w` bits,
    // never narrower than the output word.
    function automatic int unsigned acc_width(int unsigned in_w,
                                              int unsigned out_w,
                                              int unsigned states);
        int unsigned need;
        need = in_w + $clog2(states);
        return (need > out_w) ? need : out_w;
    endfunction

    // Part of the frame a bit-clock period belongs to.
    typedef enum logic [0:0] {
        SEG_DATA = 1'b0,
        SEG_IDLE = 1'b1
    } frame_seg_e;

endpackage

// File: rtl/dacavg_timer.sv
module dacavg_timer #(
    parameter int DIV    = 4,
    parameter int STATES = 21,
    parameter int PH_W   = $clog2(DIV),
    parameter int ST_W   = $clog2(STATES)
) (
    input  logic            clk,
    input  logic            rst,
    output logic            tick,
    output logic            frame_end,
    output logic [ST_W-1:0] state,
    output logic            bck
);
    typedef struct packed {
        logic [PH_W-1:0] ph;
        logic [ST_W-1:0] st;
        logic            bck;
    } tmr_t;

    tmr_t r_d, r_q;
    logic last_ph;

    assign last_ph = (r_q.ph == PH_W'(DIV - 1));

    always_comb begin
        r_d = r_q;
        if (last_ph) begin
            r_d.ph = '0;
            r_d.st = (r_q.st == ST_W'(STATES - 1)) ? '0 : r_q.st + 1'b1;
        end else begin
            r_d.ph = r_q.ph + 1'b1;
        end
        r_d.bck = (r_d.ph >= PH_W'(DIV / 2));
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign tick      = last_ph;
    assign frame_end = last_ph && (r_q.st == ST_W'(STATES - 1));
    assign state     = r_q.st;
    assign bck       = r_q.bck;

    // R1: the divider phase walks up by one every system cycle
    a_r1_phase_step: assert property (@(posedge clk) disable iff (rst)
        !last_ph |=> (r_q.ph == $past(r_q.ph) + 1'b1));

    // R2: a frame always returns to state 0 after its last period
    a_r2_frame_wrap: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> (r_q.st == '0));

    // R1: the bit clock only rises halfway through a period
    a_r1_bck_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(r_q.bck) |-> (r_q.ph == PH_W'(DIV / 2)));
endmodule

// File: rtl/dacavg_accum.sv
module dacavg_accum #(
    parameter int IN_W   = 10,
    parameter int OUT_W  = 16,
    parameter int STATES = 21,
    parameter int ACC_W  = 16,
    parameter int CNT_W  = $clog2(STATES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             frame_end,
    input  logic [IN_W-1:0]  sample,
    output logic [OUT_W-1:0] next_word
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [CNT_W-1:0] cnt;
    } acc_t;

    acc_t r_d, r_q;
    logic [ACC_W:0] sum_wide;
    logic [ACC_W-1:0] sum;

    assign sum_wide = {1'b0, r_q.acc} + (ACC_W + 1)'(sample);
    assign sum      = sum_wide[ACC_W-1:0];

    // Offset-binary to two's complement: flip the top bit of the kept slice.
    assign next_word = {~sum[ACC_W-1], sum[ACC_W-2 -: OUT_W-1]};

    always_comb begin
        r_d = r_q;
        if (tick) begin
            if (frame_end) begin
                r_d.acc = '0;
                r_d.cnt = '0;
            end else begin
                r_d.acc = sum;
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    // R4: exactly STATES-1 samples are held when the last one is added
    a_r4_sample_count: assert property (@(posedge clk) disable iff (rst)
        frame_end |-> (r_q.cnt == CNT_W'(STATES - 1)));

    // R9: the running sum never wraps
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
        tick |-> !sum_wide[ACC_W]);

    // R6: each frame starts from an empty accumulator
    a_r6_restart: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> (r_q.acc == '0));
endmodule

// File: rtl/dacavg_serial.sv
module dacavg_serial #(
    parameter int OUT_W  = 16,
    parameter int STATES = 21,
    parameter int ST_W   = $clog2(STATES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             frame_end,
    input  logic [ST_W-1:0]  state,
    input  logic [OUT_W-1:0] next_word,
    output logic             sd,
    output logic             ws
);
    import dacavg_pkg::*;

    typedef struct packed {
        logic [OUT_W-1:0] shift;
        logic             sd;
        logic             ws;
    } ser_t;

    ser_t r_d, r_q;
    frame_seg_e seg;
    logic last_bit;

    assign seg      = (state >= ST_W'(OUT_W)) ? SEG_IDLE : SEG_DATA;
    assign last_bit = tick && (state == ST_W'(OUT_W - 1));

    always_comb begin
        r_d = r_q;
        if (tick) begin
            if (frame_end) begin
                r_d.shift = next_word;
                r_d.sd    = next_word[OUT_W-1];
            end else if (state < ST_W'(OUT_W - 1)) begin
                r_d.shift = r_q.shift << 1;
                r_d.sd    = r_q.shift[OUT_W-2];
            end else begin
                r_d.sd    = 1'b0;
            end
            if (last_bit) r_d.ws = ~r_q.ws;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign sd = r_q.sd;
    assign ws = r_q.ws;

    // R2: data line is quiet during the idle periods
    a_r2_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        (seg == SEG_IDLE) |-> !r_q.sd);

    // R7: word select moves only right after the last data bit
    a_r7_ws_place: assert property (@(posedge clk) disable iff (rst)
        !$stable(r_q.ws) |-> (state == ST_W'(OUT_W)));
endmodule

// File: rtl/dacavg_drv.sv
module dacavg_drv #(
    parameter int IN_W        = 10,
    parameter int OUT_W       = 16,
    parameter int DIV         = 4,
    parameter int IDLE_STATES = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [IN_W-1:0] sample_i,
    output logic            bck_o,
    output logic            sdata_o,
    output logic            ws_o
);
    localparam int STATES = OUT_W + IDLE_STATES;
    localparam int ST_W   = $clog2(STATES);
    localparam int ACC_W  = dacavg_pkg::acc_width(IN_W, OUT_W, STATES);

    logic            tick;
    logic            frame_end;
    logic [ST_W-1:0] state;
    logic [OUT_W-1:0] next_word;

    dacavg_timer #(
        .DIV    (DIV),
        .STATES (STATES)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .frame_end (frame_end),
        .state     (state),
        .bck       (bck_o)
    );

    dacavg_accum #(
        .IN_W   (IN_W),
        .OUT_W  (OUT_W),
        .STATES (STATES),
        .ACC_W  (ACC_W)
    ) u_accum (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .frame_end (frame_end),
        .sample    (sample_i),
        .next_word (next_word)
    );

    dacavg_serial #(
        .OUT_W  (OUT_W),
        .STATES (STATES)
    ) u_serial (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .frame_end (frame_end),
        .state     (state),
        .next_word (next_word),
        .sd        (sdata_o),
        .ws        (ws_o)
    );

    // R3: serial data holds while the bit clock is high
    a_r3_data_stable: assert property (@(posedge clk) disable iff (rst)
        (bck_o && $past(bck_o)) |-> $stable(sdata_o));

    // R3: serial data only moves when the bit clock falls
    a_r3_change_on_fall: assert property (@(posedge clk) disable iff (rst)
        !$stable(sdata_o) |-> $fell(bck_o));
endmodule

// File: tb/dacavg_drv_test.sv
module dacavg_drv_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] sample = '0;
    logic       bck, sdata, ws;

    int checks = 0;
    int fails  = 0;
    bit timeout = 0;
    int frames = 0;

    localparam int NFRAMES = 36;
    localparam int FMAX = 21 * 1023;

    always #4 clk = ~clk;

    dacavg_drv uut (
        .clk      (clk),
        .rst      (rst),
        .sample_i (sample),
        .bck_o    (bck),
        .sdata_o  (sdata),
        .ws_o     (ws)
    );

    function automatic logic [9:0] pat(int n);
        int mode;
        mode = (n / 21 / 6) % 6;
        case (mode)
            0: return 10'd0;
            1: return 10'd1023;
            2: return 10'((n * 37) % 1024);
            3: return (n % 2 == 0) ? 10'd0 : 10'd1023;
            4: return 10'(((n * 1103 + 12345) ^ (n >> 3)) % 1024);
            default: return 10'(n % 7);
        endcase
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Converter model: capture on rising bck, drive new sample after falling bck.
    initial begin
        logic prev_bck, prev_ws, prev_sd;
        int idx, sum, cyc, hi, ws_ch, ws_at, ns;
        bit stab_bad, seen_rise;
        logic [15:0] cap, exp_word;
        prev_bck = 0; prev_ws = 0; prev_sd = 0;
        idx = 0; sum = 0; cyc = 0; hi = 0; ws_ch = 0; ws_at = -1; ns = 0;
        stab_bad = 0; seen_rise = 0; cap = '0; exp_word = 16'h0000;
        wait (rst == 1'b0);
        forever begin
            @(negedge clk);
            cyc++;
            if (bck) hi++;
            if (bck && prev_bck && sdata != prev_sd) stab_bad = 1;
            if (ws != prev_ws) begin
                ws_ch++;
                ws_at = idx;
            end
            if (!bck && prev_bck) begin
                check(hi == 2, "R1 high time", hi, 2);
                hi = 0;
                ns++;
                sample = pat(ns);
            end
            if (bck && !prev_bck) begin
                if (seen_rise) check(cyc == 4, "R1 period", cyc, 4);
                seen_rise = 1;
                cyc = 0;
                sum += int'(sample);
                if (idx < 16) cap = {cap[14:0], sdata};
                else check(sdata == 1'b0, "R2 idle data", int'(sdata), 0);
                idx++;
                if (idx == 21) begin
                    if (frames == 0)
                        check(cap == exp_word, "R8 first word", cap, exp_word);
                    else
                        check(cap == exp_word, "R4 R5 R6 word", cap, exp_word);
                    if (exp_word == 16'hD3EB)
                        check(cap == 16'hD3EB, "R9 full scale", cap, 16'hD3EB);
                    check(ws_ch == 1 && ws_at == 16, "R7 ws toggle", ws_ch * 100 + ws_at, 116);
                    check(!stab_bad, "R3 stable while high", int'(stab_bad), 0);
                    if (sum == FMAX)
                        check(16'(sum ^ 32'h8000) == 16'hD3EB, "R9 sum", sum, FMAX);
                    exp_word = 16'(sum) ^ 16'h8000;
                    frames++;
                    sum = 0; idx = 0; ws_ch = 0; ws_at = -1; stab_bad = 0;
                end
            end
            prev_bck = bck; prev_ws = ws; prev_sd = sdata;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        timeout = 1;
    end

    initial begin
        sample = pat(0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(bck == 1'b0, "R8 reset bck", int'(bck), 0);
        check(sdata == 1'b0, "R8 reset sdata", int'(sdata), 0);
        check(ws == 1'b0, "R8 reset ws", int'(ws), 0);
        rst = 1'b0;
        wait (frames >= NFRAMES || timeout);
        if (timeout) check(1'b0, "watchdog", frames, NFRAMES);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule